// File: doc/BRIEF.md
# CAN receive mailbox dispatcher

This block sits behind a CAN protocol engine that has already decoded a frame. It files each received frame into one of 32 receive mailboxes. The engine pulses `arb_end_i` with the received identifier once the arbitration field has been seen. The block then compares that identifier with every mailbox at once and remembers the highest-numbered mailbox that accepts it. A later `eof_ok_i` pulse, with the frame type, length and payload, commits the frame to the remembered mailbox. A `frm_err_i` pulse drops the selection instead.

Each mailbox has an identifier, an acceptance mask, a receive enable and a full-mailbox policy. Under the overwrite policy, a new frame replaces an unread one. Under the overrun policy, the unread frame is kept and the new one is thrown away. Either way the loss is recorded in a per-mailbox lost flag, which has its own interrupt source. The host sees pending flags, lost flags and three interrupt request bits on a simple word-addressed register bus. It clears them by writing ones. It steers the single interrupt line with per-mailbox and global masks.

Top module: `can_rx_dispatch`

## Requirements
- R1: After reset, all pending flags, lost flags and interrupt requests read 0, the global mask (offset 4) reads 3'b111, the mailbox mask (offset 5) reads all ones, every mailbox field reads 0, and `irq_o` is 0.
- R2: When several receive mailboxes accept the identifier, the mailbox with the highest number is selected.
- R3: A mailbox accepts an identifier only if its receive enable is 1 and the identifier equals the stored identifier on every bit whose mask bit is 0 (mask bit 1 means don't care). A frame that no mailbox accepts changes nothing.
- R4: The selection is taken when `arb_end_i` is high. It is dropped by `eof_ok_i` or `frm_err_i`. A frame ended by `frm_err_i` changes no flag, request or stored content.
- R5: On `eof_ok_i`, if the selected mailbox's pending flag for the frame type is clear, the payload and length are stored and that flag is set. Data frames (`frm_rtr_i`=0) use the data-pending register (offset 0), and remote frames use the remote-pending register (offset 1). Bit n of each register belongs to mailbox n.
- R6: A newly stored frame sets interrupt request bit 0 (data) or bit 1 (remote), but only when the mailbox's bit in the mailbox mask is 0.
- R7: If the pending flag is already set and the mailbox is in overwrite mode, the new frame replaces the stored one. The mailbox's lost flag (offset 2) is set, and request bit 2 is set if the mailbox mask bit is 0.
- R8: If the pending flag is already set and the mailbox is in overrun mode, the new frame is discarded and the stored payload and length stay unchanged. The lost flag and request bit 2 are set as in R7.
- R9: `irq_o` is 1 exactly when some request bit (offset 3) is 1 while the global mask bit in the same position is 0.
- R10: Writing 1 to a bit at offsets 0 to 3 clears it. Writing 0 leaves it unchanged.
- R11: If a hardware set and a host clear reach the same flag or request bit in the same cycle, the bit ends up set.
- R12: Address bit 7 = 0 selects the global registers at offsets 0 to 5 in bits 2:0; any other address in that half reads 0. Address bit 7 = 1 selects mailbox `addr[6:2]`, word `addr[1:0]`:
  - word 0: identifier in bits 10:0, receive enable in bit 16, overwrite mode in bit 17, and a read-only length in bits 27:24;
  - word 1: mask in bits 10:0;
  - words 2 and 3: read-only payload bits 31:0 and 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arb_end_i | input | 1 | End of arbitration field, one-cycle pulse |
| arb_id_i | input | 11 | Received identifier, valid with `arb_end_i` |
| eof_ok_i | input | 1 | Valid end of frame, one-cycle pulse |
| frm_err_i | input | 1 | Frame aborted by an error, one-cycle pulse |
| frm_rtr_i | input | 1 | Frame type with `eof_ok_i`: 1 remote, 0 data |
| frm_dlc_i | input | 4 | Length code, valid with `eof_ok_i` |
| frm_data_i | input | 64 | Payload, byte 0 in bits 7:0 |
| reg_we_i | input | 1 | Host write strobe |
| reg_addr_i | input | 8 | Host word address |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check three things on every cycle:
- the latched mailbox is the highest accepting one, and no selection is taken when nothing accepts;
- stored content holds when no store is issued, and a frame with no selection leaves the flags alone;
- a loss sets the lost flag, and a set that collides with a host clear wins.

The bench's scenarios show the rest. They cover the mask and enable semantics of acceptance, the data-versus-remote split of flags and requests, overwrite against overrun on a full mailbox, and the effect of both mask levels on `irq_o`. A reference model compares both outputs on every cycle.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  localparam int DATA_W   = 64;
  localparam int DLC_W    = 4;
  localparam int IRR_W    = 3;
  localparam int IRR_DAT  = 0;
  localparam int IRR_REM  = 1;
  localparam int IRR_LOST = 2;
  localparam int CFG_RXEN = 16;
  localparam int CFG_OVW  = 17;
  localparam int CFG_DLC  = 24;

  typedef enum logic [2:0] {
    G_DPEND  = 3'd0,
    G_RPEND  = 3'd1,
    G_LOST   = 3'd2,
    G_IRR    = 3'd3,
    G_GMASK  = 3'd4,
    G_MBMASK = 3'd5
  } greg_e;

  typedef enum logic [1:0] {
    W_CFG  = 2'd0,
    W_MASK = 2'd1,
    W_DLO  = 2'd2,
    W_DHI  = 2'd3
  } mword_e;
endpackage

// File: rtl/can_rx_search.sv
module can_rx_search #(
  parameter  int N_MB = 32,
  parameter  int ID_W = 11,
  localparam int MB_W = $clog2(N_MB)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      arb_end_i,
  input  logic [ID_W-1:0]           id_i,
  input  logic                      frm_done_i,
  input  logic [N_MB-1:0][ID_W-1:0] mb_id_i,
  input  logic [N_MB-1:0][ID_W-1:0] mb_mask_i,
  input  logic [N_MB-1:0]           mb_rxen_i,
  output logic                      sel_vld_o,
  output logic [MB_W-1:0]           sel_idx_o
);
  logic [N_MB-1:0] match;
  logic            hit;
  logic [MB_W-1:0] hit_idx;

  for (genvar g = 0; g < N_MB; g++) begin : g_cmp
    assign match[g] = mb_rxen_i[g] && (((id_i ^ mb_id_i[g]) & ~mb_mask_i[g]) == '0);
  end

  // later (higher) index overrides: highest match wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < N_MB; i++) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = MB_W'(i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_vld_o <= 1'b0;
      sel_idx_o <= '0;
    end else if (arb_end_i) begin
      sel_vld_o <= hit;
      sel_idx_o <= hit_idx;
    end else if (frm_done_i) begin
      sel_vld_o <= 1'b0;
    end
  end

  p_sel_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_end_i && (match != '0) |=> sel_vld_o && (($past(match) >> sel_idx_o) == N_MB'(1)));

  p_sel_none_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_end_i && (match == '0) |=> !sel_vld_o);
endmodule

// File: rtl/can_rx_store.sv
module can_rx_store import can_rx_pkg::*; #(
  parameter  int N_MB = 32,
  localparam int MB_W = $clog2(N_MB)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [MB_W-1:0]             wr_idx_i,
  input  logic [DLC_W-1:0]            dlc_i,
  input  logic [DATA_W-1:0]           data_i,
  output logic [N_MB-1:0][DLC_W-1:0]  dlc_o,
  output logic [N_MB-1:0][DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dlc_o  <= '0;
      data_o <= '0;
    end else if (wr_en_i) begin
      dlc_o[wr_idx_i]  <= dlc_i;
      data_o[wr_idx_i] <= data_i;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(data_o) && $stable(dlc_o));
endmodule

// File: rtl/can_rx_dispatch.sv
module can_rx_dispatch import can_rx_pkg::*; #(
  parameter  int N_MB   = 32,
  parameter  int ID_W   = 11,
  localparam int MB_W   = $clog2(N_MB),
  localparam int ADDR_W = MB_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arb_end_i,
  input  logic [ID_W-1:0]   arb_id_i,
  input  logic              eof_ok_i,
  input  logic              frm_err_i,
  input  logic              frm_rtr_i,
  input  logic [DLC_W-1:0]  frm_dlc_i,
  input  logic [DATA_W-1:0] frm_data_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  logic [N_MB-1:0][ID_W-1:0]   id_q, mask_q;
  logic [N_MB-1:0]             rxen_q, ovw_q, dpend_q, rpend_q, lost_q, mbmask_q;
  logic [IRR_W-1:0]            irr_q, gmask_q;
  logic                        sel_vld;
  logic [MB_W-1:0]             sel_idx;
  logic [N_MB-1:0][DLC_W-1:0]  dlc_q;
  logic [N_MB-1:0][DATA_W-1:0] data_q;

  can_rx_search #(.N_MB(N_MB), .ID_W(ID_W)) u_search (
    .clk_i, .rst_ni, .arb_end_i,
    .id_i       (arb_id_i),
    .frm_done_i (eof_ok_i | frm_err_i),
    .mb_id_i    (id_q),
    .mb_mask_i  (mask_q),
    .mb_rxen_i  (rxen_q),
    .sel_vld_o  (sel_vld),
    .sel_idx_o  (sel_idx)
  );

  // frame commit
  logic            ev, pend_hit, ev_new, ev_loss, st_wr, mb_en;
  logic [N_MB-1:0] sel_oh;
  assign sel_oh   = N_MB'(1) << sel_idx;
  assign ev       = eof_ok_i && sel_vld;
  assign pend_hit = frm_rtr_i ? rpend_q[sel_idx] : dpend_q[sel_idx];
  assign ev_new   = ev && !pend_hit;
  assign ev_loss  = ev && pend_hit;
  assign st_wr    = ev_new || (ev_loss && ovw_q[sel_idx]);
  assign mb_en    = !mbmask_q[sel_idx];

  can_rx_store #(.N_MB(N_MB)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i  (st_wr),
    .wr_idx_i (sel_idx),
    .dlc_i    (frm_dlc_i),
    .data_i   (frm_data_i),
    .dlc_o    (dlc_q),
    .data_o   (data_q)
  );

  // host decode
  logic              g_hit, g_wr, m_wr;
  logic [2:0]        g_off;
  logic [MB_W-1:0]   m_idx;
  logic [1:0]        m_word;
  assign g_off  = reg_addr_i[2:0];
  assign m_idx  = reg_addr_i[ADDR_W-2:2];
  assign m_word = reg_addr_i[1:0];
  assign g_hit  = !reg_addr_i[ADDR_W-1] && (reg_addr_i[ADDR_W-2:3] == '0);
  assign g_wr   = reg_we_i && g_hit;
  assign m_wr   = reg_we_i && reg_addr_i[ADDR_W-1];

  logic [N_MB-1:0]  dp_clr, rp_clr, ls_clr, dp_set, rp_set, ls_set;
  logic [IRR_W-1:0] irr_clr, irr_set;
  assign dp_clr  = (g_wr && g_off == G_DPEND) ? reg_wdata_i[N_MB-1:0]  : '0;
  assign rp_clr  = (g_wr && g_off == G_RPEND) ? reg_wdata_i[N_MB-1:0]  : '0;
  assign ls_clr  = (g_wr && g_off == G_LOST)  ? reg_wdata_i[N_MB-1:0]  : '0;
  assign irr_clr = (g_wr && g_off == G_IRR)   ? reg_wdata_i[IRR_W-1:0] : '0;
  assign dp_set  = (ev_new && !frm_rtr_i) ? sel_oh : '0;
  assign rp_set  = (ev_new &&  frm_rtr_i) ? sel_oh : '0;
  assign ls_set  = ev_loss ? sel_oh : '0;

  always_comb begin
    irr_set           = '0;
    irr_set[IRR_DAT]  = ev_new && !frm_rtr_i && mb_en;
    irr_set[IRR_REM]  = ev_new &&  frm_rtr_i && mb_en;
    irr_set[IRR_LOST] = ev_loss && mb_en;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dpend_q  <= '0;
      rpend_q  <= '0;
      lost_q   <= '0;
      irr_q    <= '0;
      gmask_q  <= '1;
      mbmask_q <= '1;
    end else begin
      dpend_q <= (dpend_q & ~dp_clr)  | dp_set;
      rpend_q <= (rpend_q & ~rp_clr)  | rp_set;
      lost_q  <= (lost_q  & ~ls_clr)  | ls_set;
      irr_q   <= (irr_q   & ~irr_clr) | irr_set;
      if (g_wr && g_off == G_GMASK)  gmask_q  <= reg_wdata_i[IRR_W-1:0];
      if (g_wr && g_off == G_MBMASK) mbmask_q <= reg_wdata_i[N_MB-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q   <= '0;
      mask_q <= '0;
      rxen_q <= '0;
      ovw_q  <= '0;
    end else if (m_wr) begin
      if (m_word == W_CFG) begin
        id_q[m_idx]   <= reg_wdata_i[ID_W-1:0];
        rxen_q[m_idx] <= reg_wdata_i[CFG_RXEN];
        ovw_q[m_idx]  <= reg_wdata_i[CFG_OVW];
      end
      if (m_word == W_MASK) mask_q[m_idx] <= reg_wdata_i[ID_W-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[ADDR_W-1]) begin
      case (m_word)
        W_CFG: begin
          reg_rdata_o[ID_W-1:0]         = id_q[m_idx];
          reg_rdata_o[CFG_RXEN]         = rxen_q[m_idx];
          reg_rdata_o[CFG_OVW]          = ovw_q[m_idx];
          reg_rdata_o[CFG_DLC +: DLC_W] = dlc_q[m_idx];
        end
        W_MASK: reg_rdata_o[ID_W-1:0] = mask_q[m_idx];
        W_DLO:  reg_rdata_o = data_q[m_idx][31:0];
        W_DHI:  reg_rdata_o = data_q[m_idx][63:32];
      endcase
    end else if (g_hit) begin
      case (g_off)
        G_DPEND:  reg_rdata_o[N_MB-1:0]  = dpend_q;
        G_RPEND:  reg_rdata_o[N_MB-1:0]  = rpend_q;
        G_LOST:   reg_rdata_o[N_MB-1:0]  = lost_q;
        G_IRR:    reg_rdata_o[IRR_W-1:0] = irr_q;
        G_GMASK:  reg_rdata_o[IRR_W-1:0] = gmask_q;
        G_MBMASK: reg_rdata_o[N_MB-1:0]  = mbmask_q;
        default:  reg_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(irr_q & ~gmask_q);

  p_ignore_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_ok_i || frm_err_i) && !sel_vld && !reg_we_i |=>
      $stable(dpend_q) && $stable(rpend_q) && $stable(lost_q) && $stable(irr_q));

  p_rx_irr_dat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_new && mb_en && !frm_rtr_i |=> irr_q[IRR_DAT]);

  p_rx_irr_rem_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_new && mb_en && frm_rtr_i |=> irr_q[IRR_REM]);

  p_loss_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_loss |=> lost_q[$past(sel_idx)]);

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_new && !frm_rtr_i && dp_clr[sel_idx] |=> dpend_q[$past(sel_idx)]);
endmodule

// File: tb/test_can_rx_dispatch.sv
module test_can_rx_dispatch;
  localparam int N = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arb_end = 1'b0;
  logic [10:0] arb_id = '0;
  logic        eof_ok = 1'b0, frm_err = 1'b0, rtr = 1'b0;
  logic [3:0]  dlc = '0;
  logic [63:0] data = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  always #2 clk_i = ~clk_i;

  can_rx_dispatch i_can_rx_dispatch (
    .clk_i, .rst_ni,
    .arb_end_i (arb_end), .arb_id_i (arb_id),
    .eof_ok_i (eof_ok), .frm_err_i (frm_err), .frm_rtr_i (rtr),
    .frm_dlc_i (dlc), .frm_data_i (data),
    .reg_we_i (we), .reg_addr_i (addr), .reg_wdata_i (wdata),
    .reg_rdata_o (rdata), .irq_o (irq)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  // reference model
  logic [10:0] m_id [N];
  logic [10:0] m_mask [N];
  logic [3:0]  m_dlc [N];
  logic [63:0] m_data [N];
  logic [31:0] m_rxen, m_ovw, m_dp, m_rp, m_lost, m_mbm;
  logic [2:0]  m_irr, m_gm;
  bit          m_sv;
  int          m_si;

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin
      m_id[i] = '0; m_mask[i] = '0; m_dlc[i] = '0; m_data[i] = '0;
    end
    m_rxen = '0; m_ovw = '0; m_dp = '0; m_rp = '0; m_lost = '0;
    m_mbm = '1; m_irr = '0; m_gm = 3'b111; m_sv = 0; m_si = 0;
  endtask

  task automatic m_step();
    int hit, mb;
    bit pend;
    logic [31:0] dps = '0, rps = '0, lss = '0;
    logic [2:0]  is = '0;
    if (eof_ok && m_sv) begin
      pend = rtr ? m_rp[m_si] : m_dp[m_si];
      if (!pend) begin
        if (rtr) rps[m_si] = 1'b1; else dps[m_si] = 1'b1;
        if (!m_mbm[m_si]) is[rtr ? 1 : 0] = 1'b1;
        m_data[m_si] = data; m_dlc[m_si] = dlc;
      end else begin
        lss[m_si] = 1'b1;
        if (!m_mbm[m_si]) is[2] = 1'b1;
        if (m_ovw[m_si]) begin m_data[m_si] = data; m_dlc[m_si] = dlc; end
      end
    end
    hit = -1;
    for (int i = N - 1; i >= 0; i--)
      if (hit < 0 && m_rxen[i] && (((arb_id ^ m_id[i]) & ~m_mask[i]) == 0)) hit = i;
    if (we) begin
      if (addr[7]) begin
        mb = int'(addr[6:2]);
        case (addr[1:0])
          2'd0: begin m_id[mb] = wdata[10:0]; m_rxen[mb] = wdata[16]; m_ovw[mb] = wdata[17]; end
          2'd1: m_mask[mb] = wdata[10:0];
          default: ;
        endcase
      end else if (addr[6:3] == 0) begin
        case (addr[2:0])
          3'd0: m_dp   &= ~wdata;
          3'd1: m_rp   &= ~wdata;
          3'd2: m_lost &= ~wdata;
          3'd3: m_irr  &= ~wdata[2:0];
          3'd4: m_gm    = wdata[2:0];
          3'd5: m_mbm   = wdata;
          default: ;
        endcase
      end
    end
    m_dp |= dps; m_rp |= rps; m_lost |= lss; m_irr |= is;
    if (arb_end) begin
      m_sv = (hit >= 0);
      if (hit >= 0) m_si = hit;
    end else if (eof_ok || frm_err) m_sv = 0;
  endtask

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] r = '0;
    int mb = int'(a[6:2]);
    if (a[7]) begin
      case (a[1:0])
        2'd0: begin r[10:0] = m_id[mb]; r[16] = m_rxen[mb]; r[17] = m_ovw[mb]; r[27:24] = m_dlc[mb]; end
        2'd1: r[10:0] = m_mask[mb];
        2'd2: r = m_data[mb][31:0];
        default: r = m_data[mb][63:32];
      endcase
    end else if (a[6:3] == 0) begin
      case (a[2:0])
        3'd0: r = m_dp;
        3'd1: r = m_rp;
        3'd2: r = m_lost;
        3'd3: r[2:0] = m_irr;
        3'd4: r[2:0] = m_gm;
        3'd5: r = m_mbm;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  initial m_reset();
  always @(posedge clk_i) begin
    if (!rst_ni) m_reset();
    else m_step();
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      check("irq_o", 32'(irq), 32'(|(m_irr & ~m_gm)));
      check($sformatf("rdata@%h", addr), rdata, m_read(addr));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1; tick(); we = 1'b0;
  endtask

  task automatic peek(logic [7:0] a);
    addr = a; tick();
  endtask

  function automatic logic [7:0] mba(int mb, int w);
    return {1'b1, 5'(mb), 2'(w)};
  endfunction

  task automatic frame(logic [10:0] id, bit r, logic [3:0] l, logic [63:0] d, bit bad);
    arb_id = id; arb_end = 1'b1; tick(); arb_end = 1'b0; tick(2);
    rtr = r; dlc = l; data = d;
    if (bad) frm_err = 1'b1; else eof_ok = 1'b1;
    tick(); eof_ok = 1'b0; frm_err = 1'b0; tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(5);
    rst_ni = 1'b1;
    tick();
    cur_req = "R1";
    for (int a = 0; a < 8; a++) peek(8'(a));
    peek(mba(31, 0)); peek(mba(0, 2));

    cur_req = "R12";
    wr(mba(31, 0), 32'h0001_0123);
    wr(mba(20, 0), 32'h0001_0120);
    wr(mba(20, 1), 32'h0000_000F);
    wr(mba(3, 0),  32'h0000_0600);
    wr(mba(9, 0),  32'h0001_0200);
    peek(mba(31, 0)); peek(mba(20, 1)); peek(mba(3, 0)); peek(8'h09); peek(8'h48);

    cur_req = "R2";   // 0x123 fits both 31 and 20
    frame(11'h123, 0, 4'd8, 64'h1111_2222_3333_4444, 0);
    peek(8'h00); peek(mba(31, 2)); peek(mba(31, 3));
    frame(11'h12A, 0, 4'd2, 64'h0000_0000_0000_BEEF, 0);
    peek(8'h00); peek(mba(20, 2));

    cur_req = "R3";   // disabled mailbox and no-match id
    frame(11'h600, 0, 4'd1, 64'h55, 0);
    frame(11'h7FF, 0, 4'd1, 64'h66, 0);
    peek(8'h00); peek(8'h02); peek(mba(3, 2));

    cur_req = "R4";   // error frame to a full mailbox: no loss
    frame(11'h123, 0, 4'd3, 64'hDEAD, 1);
    peek(8'h02); peek(mba(31, 2)); peek(8'h03);

    cur_req = "R5";
    frame(11'h200, 1, 4'd0, 64'h0, 0);
    peek(8'h01); peek(8'h00); peek(mba(9, 0)); peek(mba(31, 0));

    cur_req = "R6";
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h01, 32'hFFFF_FFFF);
    wr(8'h05, ~32'h8010_0200);
    frame(11'h123, 0, 4'd7, 64'hA5A5_A5A5_0000_0001, 0);
    peek(8'h03);
    frame(11'h200, 1, 4'd0, 64'h0, 0);
    peek(8'h03); peek(8'h01);

    cur_req = "R9";
    wr(8'h04, 32'h6); peek(8'h03);
    wr(8'h04, 32'h5); peek(8'h03);
    wr(8'h04, 32'h3); peek(8'h04);
    wr(8'h03, 32'h7); peek(8'h03);
    wr(8'h04, 32'h0);

    cur_req = "R7";   // mailbox 31 overwrite, still pending
    wr(mba(31, 0), 32'h0003_0123);
    frame(11'h123, 0, 4'd5, 64'hCAFE_F00D_1234_5678, 0);
    peek(mba(31, 2)); peek(mba(31, 3)); peek(mba(31, 0)); peek(8'h02); peek(8'h03);

    cur_req = "R8";   // mailbox 20 overrun
    frame(11'h12A, 0, 4'd4, 64'h0000_0000_AAAA_0001, 0);
    frame(11'h12B, 0, 4'd6, 64'h9999_9999_BBBB_0002, 0);
    peek(mba(20, 2)); peek(mba(20, 3)); peek(mba(20, 0)); peek(8'h02);

    cur_req = "R10";
    wr(8'h00, 32'h0); peek(8'h00);
    wr(8'h02, 32'h0); peek(8'h02);
    wr(8'h02, 32'h8000_0000); peek(8'h02);
    wr(8'h03, 32'h0); peek(8'h03);
    wr(8'h03, 32'h7); peek(8'h03);

    cur_req = "R11";  // clear and set of mailbox 20 data flag together
    wr(8'h00, 32'h0010_0000); peek(8'h00);
    arb_id = 11'h12A; arb_end = 1'b1; tick(); arb_end = 1'b0; tick(2);
    rtr = 1'b0; dlc = 4'd1; data = 64'h77;
    eof_ok = 1'b1; we = 1'b1; addr = 8'h00; wdata = 32'h0010_0000;
    tick(); eof_ok = 1'b0; we = 1'b0;
    peek(8'h00); peek(mba(20, 2)); peek(8'h03);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule